// File: doc/BRIEF.md
# Oversampled Programmable Clock Divider with Stop and Source Handover

This block produces a divided clock from one of several slow source clocks. Software programs a single control word through a small register port. The word holds a divide code, a stop flag and, when the block is built with more than one source, a source-select field. The output period is (code + 1) periods of the selected source. A stop flag parks the output low. Changing the source moves the output to the new clock through a parked-low handover, so no short pulse appears.

The block runs on one fast system clock. Every source clock is synchronised into that domain and followed by an edge detector. The output is built from registered state in the system domain. For a ratio of 1 it is the synchronised source level, gated. All settings change only at an output period boundary. A second register holds status: a sticky error flag, a running flag and a handover-busy flag.

The register port and the status pins are plain control signals and carry no valid/ready handshake. A write takes effect in the cycle it is presented. A read is combinational on the address and is never back-pressured. Address 0 selects the control word and address 1 selects the status word.

Top module: `clkdiv_gen`

## Requirements
- R1: After reset the control word reads 0 (divide code 0, stop clear, select 0) and status bit 0 (error) reads 0.
- R2: With divide code D > 0 and stop clear, the output repeats every D+1 source periods. It is high for ceil((D+1)/2) source periods and low for floor((D+1)/2) source periods.
- R3: With divide code 0 and stop clear, the output follows the selected source, high for one source half-period and low for one source half-period.
- R4: Control bit 8 is the stop flag. Once it is set and the current period has ended, the output stays low and status bit 1 (running) reads 0.
- R5: Writing the stop flag together with a non-zero divide code stores that code unchanged. Clearing the stop flag later restarts the output at that ratio.
- R6: A write that sets the stop flag with divide code 0 stores 0x3F as the code and sets status bit 0. That bit stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set.
- R7: With 4 sources the select field is control bits [7:6]. With 8 sources it is bits [14:12]. With 1 source there is no select field. The output is derived from the selected source.
- R8: Control bits that are not defined for the configured source count read 0, and writing them has no effect.
- R9: A new divide code written in the middle of a period does not shorten the current period. The old high and low phases complete first.
- R10: On a source change the output is held low and status bit 2 (handover busy) reads 1. The new settings start on the second rising edge of the new source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than every source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| src_clk | input | NSRC | Source clocks, sampled in the clk domain |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The assertions rely on each source level lasting at least two system clock cycles, so that the synchroniser sees every edge. They also rely on the register port being driven as single-cycle writes on the system clock. The bench derives its sources from the system clock, toggling each one every 2 to 5 cycles on the falling edge. As a result every measured pulse length is an exact multiple of the source half-period. The stimulus mixes random divide codes and source selections with directed cases: a stop with a zero code, writes to the undefined bits, a mid-period ratio change, and a handover taken while stopped.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W    = 6;
  localparam int STOP_BIT = 8;

  // lowest bit of the source-select field for a given source count
  function automatic int sel_lsb(input int n);
    return (n == 8) ? 12 : 6;
  endfunction

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int SW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             st_running,
  input  logic             st_handover,
  output logic [DIV_W-1:0] div_q,
  output logic             stop_q,
  output logic [SW-1:0]    sel_q
);
  localparam int SL = sel_lsb(NSRC);
  localparam logic [31:0] SEL_MASK  = (NSRC > 1) ? (((32'd1 << SW) - 32'd1) << SL) : 32'd0;
  localparam logic [31:0] CTRL_MASK = SEL_MASK | (32'd1 << STOP_BIT) | ((32'd1 << DIV_W) - 32'd1);

  logic err_q;
  logic wr_ctrl, wr_stat, stop_bad;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wr_ctrl  = reg_wr & ~reg_addr;
  assign wr_stat  = reg_wr & reg_addr;
  assign stop_bad = reg_wdata[STOP_BIT] && (reg_wdata[DIV_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      stop_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        stop_q <= reg_wdata[STOP_BIT];
        div_q  <= stop_bad ? '1 : reg_wdata[DIV_W-1:0];
      end
      if (wr_ctrl && stop_bad)
        err_q <= 1'b1;
      else if (wr_stat && reg_wdata[0])
        err_q <= 1'b0;
    end
  end

  generate
    if (NSRC > 1) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel_q <= '0;
        else if (wr_ctrl) sel_q <= reg_wdata[SL +: SW];
      end
    end else begin : g_nosel
      assign sel_q = '0;
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[DIV_W-1:0] = div_q;
      reg_rdata[STOP_BIT]  = stop_q;
      if (NSRC > 1) reg_rdata[SL +: SW] = sel_q;
    end else begin
      reg_rdata[2:0] = {st_handover, st_running, err_q};
    end
  end

  // R6
  stop_div_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (div_q != '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_stat && reg_wdata[0])) |=> err_q);

  // R8
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> ((reg_rdata & ~CTRL_MASK) == 32'd0));
endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  output logic [NSRC-1:0] lvl,
  output logic [NSRC-1:0] rise,
  output logic [NSRC-1:0] fall
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], src_clk[gi]};
    end
    assign lvl[gi]  = sh[2];
    assign rise[gi] = sh[1] & ~sh[2];
    assign fall[gi] = ~sh[1] & sh[2];
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int SW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] r_div,
  input  logic             r_stop,
  input  logic [SW-1:0]    r_sel,
  input  logic [NSRC-1:0]  lvl,
  input  logic [NSRC-1:0]  rise,
  input  logic [NSRC-1:0]  fall,
  output logic             clk_out,
  output logic             running,
  output logic             handover
);
  logic [DIV_W-1:0] a_div, cnt;
  logic [SW-1:0]    a_sel, t_sel;
  logic             out_q, pass_q, idle_q, hand_q, hcnt;
  logic             rise_a, fall_a, rise_t, sel_chg, bnd;
  logic [DIV_W:0]   hi_len, nxt;

  assign rise_a  = rise[a_sel];
  assign fall_a  = fall[a_sel];
  assign rise_t  = rise[t_sel];
  assign sel_chg = (r_sel != a_sel);
  assign hi_len  = ({1'b0, a_div} + 7'd2) >> 1;
  assign nxt     = {1'b0, cnt} + 7'd1;

  always_comb begin
    if (idle_q)      bnd = sel_chg | rise_a;
    else if (pass_q) bnd = fall_a;
    else             bnd = rise_a && (cnt == a_div);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div <= '0; a_sel <= '0; t_sel <= '0; cnt <= '0;
      out_q <= 1'b0; pass_q <= 1'b0; idle_q <= 1'b1;
      hand_q <= 1'b0; hcnt <= 1'b0;
    end else if (hand_q) begin
      if (rise_t) begin
        if (hcnt) begin
          hand_q <= 1'b0;
          a_sel  <= t_sel;
          a_div  <= r_div;
          cnt    <= '0;
          if (!r_stop) begin
            idle_q <= 1'b0;
            pass_q <= (r_div == '0);
            out_q  <= (r_div != '0);
          end
        end else begin
          hcnt <= 1'b1;
        end
      end
    end else if (bnd) begin
      if (sel_chg) begin
        hand_q <= 1'b1; hcnt <= 1'b0; t_sel <= r_sel;
        out_q <= 1'b0; pass_q <= 1'b0; idle_q <= 1'b1;
      end else if (r_stop) begin
        idle_q <= 1'b1; out_q <= 1'b0; pass_q <= 1'b0; a_div <= r_div;
      end else if (pass_q) begin
        // boundary was a falling edge: a new ratio waits for the next rise
        if (r_div != '0) begin
          idle_q <= 1'b1; pass_q <= 1'b0; out_q <= 1'b0; a_div <= r_div;
        end
      end else begin
        idle_q <= 1'b0;
        a_div  <= r_div;
        cnt    <= '0;
        pass_q <= (r_div == '0);
        out_q  <= (r_div != '0);
      end
    end else if (!idle_q && !pass_q && rise_a) begin
      cnt   <= cnt + 1'b1;
      out_q <= (nxt < hi_len);
    end
  end

  assign clk_out  = pass_q ? lvl[a_sel] : out_q;
  assign running  = ~idle_q;
  assign handover = hand_q;

  // R10
  hand_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_q |-> !clk_out);

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !clk_out);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && !pass_q) |-> (cnt <= a_div));

  // R2
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(|rise));
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NSRC-1:0] src_clk,
  output logic            clk_out
);
  localparam int SW = sel_width(NSRC);

  logic [DIV_W-1:0] div_q;
  logic             stop_q, running, handover;
  logic [SW-1:0]    sel_q;
  logic [NSRC-1:0]  lvl, rise, fall;

  clkdiv_regs #(.NSRC(NSRC), .SW(SW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_running(running), .st_handover(handover),
    .div_q(div_q), .stop_q(stop_q), .sel_q(sel_q)
  );

  clkdiv_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  clkdiv_core #(.NSRC(NSRC), .SW(SW)) u_core (
    .clk(clk), .rst_n(rst_n), .r_div(div_q), .r_stop(stop_q), .r_sel(sel_q),
    .lvl(lvl), .rise(rise), .fall(fall),
    .clk_out(clk_out), .running(running), .handover(handover)
  );
endmodule

// File: tb/clkdiv_gen_bench.sv
`timescale 1ns/1ps
module clkdiv_gen_bench;
  localparam int NSRC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NSRC-1:0] src_clk = '0;
  logic        clk_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clkdiv_gen #(.NSRC(NSRC)) u_clkdiv_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_clk(src_clk), .clk_out(clk_out)
  );

  // source i toggles every 2+i system cycles
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_srcgen
    initial begin
      forever begin
        repeat (2 + gi) @(negedge clk);
        src_clk[gi] = ~src_clk[gi];
      end
    end
  end

  function automatic int half_of(input int sel);
    return 2 + sel;
  endfunction

  function automatic int exp_hi(input int dv, input int h);
    return (dv == 0) ? h : ((dv + 2) / 2) * 2 * h;
  endfunction

  function automatic int exp_lo(input int dv, input int h);
    return (dv == 0) ? h : ((dv + 1) / 2) * 2 * h;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_rises(input int n);
    for (int k = 0; k < n; k++) begin
      int t = 0;
      while (clk_out !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
      while (clk_out !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    end
  endtask

  task automatic measure(output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (clk_out !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    while (clk_out !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    while (clk_out === 1'b1 && hi < 3000) begin @(negedge clk); hi++; end
    while (clk_out === 1'b0 && lo < 3000) begin @(negedge clk); lo++; end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, lo, sel, dv, highs;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, d); chk("R1 ctrl", d, 32'h0);
    rd(1'b1, d); chk("R1 err", d & 1, 0);

    // R3 pass-through on source 2
    wr(1'b0, 32'h080);
    wait_rises(3); measure(hi, lo);
    chk("R3 hi", hi, half_of(2)); chk("R3 lo", lo, half_of(2));

    // R2 odd ratio 5 on source 1
    wr(1'b0, 32'h044);
    wait_rises(3); measure(hi, lo);
    chk("R2 odd hi", hi, exp_hi(4, 3)); chk("R2 odd lo", lo, exp_lo(4, 3));

    // R2 R7 random selections and codes
    for (int k = 0; k < 8; k++) begin
      sel = $urandom % 4;
      dv  = $urandom % 10;
      wr(1'b0, (sel << 6) | dv);
      wait_rises(3); measure(hi, lo);
      chk("R2/R7 hi", hi, exp_hi(dv, half_of(sel)));
      chk("R2/R7 lo", lo, exp_lo(dv, half_of(sel)));
    end

    // R2 largest ratio, source 0
    wr(1'b0, 32'h03F);
    wait_rises(2); measure(hi, lo);
    chk("R2 max hi", hi, exp_hi(63, 2)); chk("R2 max lo", lo, exp_lo(63, 2));

    // R9 mid-period change keeps current period
    wait_rises(1);
    hi = 0;
    while (clk_out === 1'b1 && hi < 3000) begin
      if (hi == 10) begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h001; end
      else reg_wr = 1'b0;
      @(negedge clk); hi++;
    end
    reg_wr = 1'b0;
    lo = 0;
    while (clk_out === 1'b0 && lo < 3000) begin @(negedge clk); lo++; end
    chk("R9 hi", hi, exp_hi(63, 2)); chk("R9 lo", lo, exp_lo(63, 2));
    measure(hi, lo);
    chk("R9 new hi", hi, exp_hi(1, 2));

    // R4 R5 stop with nonzero code
    wr(1'b0, 32'h105);
    repeat (400) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (clk_out) highs++; end
    chk("R4 held low", highs, 0);
    rd(1'b1, d); chk("R4 running", (d >> 1) & 1, 0);
    rd(1'b0, d); chk("R5 kept code", d, 32'h105);
    wr(1'b0, 32'h005);
    wait_rises(3); measure(hi, lo);
    chk("R5 restart hi", hi, exp_hi(5, 2)); chk("R5 restart lo", lo, exp_lo(5, 2));
    rd(1'b1, d); chk("R4 running on", (d >> 1) & 1, 1);

    // R6 stop with zero code
    wr(1'b0, 32'h140);
    rd(1'b0, d); chk("R6 forced", d, 32'h17F);
    rd(1'b1, d); chk("R6 err set", d & 1, 1);
    wr(1'b1, 32'h0);
    rd(1'b1, d); chk("R6 err sticky", d & 1, 1);
    wr(1'b1, 32'h1);
    rd(1'b1, d); chk("R6 err clear", d & 1, 0);

    // R8 undefined bits
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R8 readback", d, 32'h1FF);
    rd(1'b1, d); chk("R8 no err", d & 1, 0);

    // R10 handover while stopped, then run on source 3
    repeat (100) @(negedge clk);
    wr(1'b0, 32'h105);
    rd(1'b1, d); chk("R10 busy", (d >> 2) & 1, 1);
    chk("R10 low", clk_out, 0);
    repeat (100) @(negedge clk);
    rd(1'b1, d); chk("R10 done", (d >> 2) & 1, 0);
    wr(1'b0, 32'h0C2);
    wait_rises(3); measure(hi, lo);
    chk("R10 hi", hi, exp_hi(2, 5)); chk("R10 lo", lo, exp_lo(2, 5));

    summary();
    $finish;
  end
endmodule